// File: doc/BRIEF.md
# Single-Bank SDRAM Read Command Sequencer

This block turns read requests, each a row, a column and a burst-length code, into the activate, read and precharge commands one SDRAM bank expects. It drives a shared address bus and three active-low strobes, and the memory samples all of them on the rising clock edge. Every command is held off until the programmed minimum spacings allow it: activate-to-read delay, row precharge time, minimum row-active time, read-to-precharge spacing and the one- or two-cycle command rate. Each command goes out in the first cycle that all of its limits permit.

The sequencer remembers which row is open. A request to that row goes straight to a read. A request to another row closes the open row, opens the new one and then reads. A single-entry holding register takes one request at a time through a valid/ready handshake. A data-valid output marks each beat of returned read data, starting after the programmed CAS latency.

Top module: `sdram_bank_seq`

## Requirements
- R1: After reset the command bus shows NOP (RAS, CAS, WE all high), `rdValid` is low and `reqReady` is high.
- R2: Command encodings on {RAS, CAS, WE} are NOP = 111, ACTIVATE = 011, READ = 101, PRECHARGE = 010. ACTIVATE carries the row on `sdAddr` and READ carries the column. Burst code 0 selects 2 words, 1 selects 4, and 2 or 3 select 8.
- R3: With no row open, an accepted request gives ACTIVATE two cycles after the accept cycle, and READ exactly max(tRCD, rate) cycles after that ACTIVATE. A READ is never closer than tRCD to the ACTIVATE that opened its row.
- R4: `rdValid` is high for exactly burst-length consecutive cycles, starting exactly CL cycles after each READ. Back-to-back bursts join with no gap.
- R5: A request to the open row issues READ with no ACTIVATE, two cycles after the accept cycle when idle. Consecutive READs are at least the previous burst length apart, and exactly that far when requests are waiting.
- R6: A request to a different row issues PRECHARGE, then ACTIVATE, then READ. PRECHARGE waits until at least tRAS cycles after the last ACTIVATE and at least the burst length after the last READ, and it is issued in the first cycle both limits allow.
- R7: ACTIVATE comes exactly max(tRP, rate) cycles after PRECHARGE when nothing else is pending.
- R8: Any two commands are at least 1 cycle apart with `cfgRate2` = 0, and at least 2 cycles apart with `cfgRate2` = 1.
- R9: `reqReady` falls in the cycle after a request is accepted and stays low until that request's READ has been decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Holding register free; a request is accepted when valid and ready are both high |
| reqRow | input | ROW_W | Row of the request |
| reqCol | input | COL_W | Column of the request |
| reqBurst | input | 2 | Burst code: 0 for 2 words, 1 for 4, 2 or 3 for 8 |
| cfgCl | input | TW | CAS latency in cycles (0 treated as 1) |
| cfgTrcd | input | TW | Activate-to-read delay (0 treated as 1) |
| cfgTrp | input | TW | Precharge-to-activate delay (0 treated as 1) |
| cfgTras | input | TW | Activate-to-precharge minimum (0 treated as 1) |
| cfgRate2 | input | 1 | 1 selects two-cycle command spacing |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write-enable strobe, active low |
| sdAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| rdValid | output | 1 | A read data beat is valid in this cycle |

## Verification
The spacing properties compare each command with counters of cycles since the previous one. They assume the timing inputs are nonzero and change only while nothing is pending and no burst is in flight, and that `reqValid` stays high until the request is accepted. The stimulus changes the timing values only after long idle gaps, never programs a zero, and holds each request until the handshake completes. Every command is then checked against the programmed minimums, and selected sequences are also checked for exact issue cycles.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {RAS, CAS, WE}, active low
  typedef enum logic [2:0] {
    CMD_NOP  = 3'b111,
    CMD_ACT  = 3'b011,
    CMD_READ = 3'b101,
    CMD_PRE  = 3'b010
  } cmd_e;

  typedef struct packed {
    logic capture;
    logic doAct;
    logic doRead;
    logic doPre;
  } strobe_t;

  function automatic logic [3:0] burstWords(input logic [1:0] code);
    case (code)
      2'd0:    burstWords = 4'd2;
      2'd1:    burstWords = 4'd4;
      default: burstWords = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (load)      cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          rowHit,
  input  logic [3:0]    burstLen,
  input  logic [TW-1:0] cfgTrcd,
  input  logic [TW-1:0] cfgTrp,
  input  logic [TW-1:0] cfgTras,
  input  logic          cfgRate2,
  output logic          reqReady,
  output strobe_t       strb
);
  localparam int NT = 5;
  localparam int T_CMD = 0, T_RCD = 1, T_RAS = 2, T_RP = 3, T_GAP = 4;

  logic pendValid;
  logic rowOpen;
  logic anyCmd;
  logic [NT-1:0]  tLoad;
  logic [NT-1:0]  tDone;
  logic [TW-1:0]  tVal [NT];

  function automatic logic [TW-1:0] lessOne(input logic [TW-1:0] v);
    lessOne = (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_comb begin
    strb = '0;
    strb.capture = reqValid && !pendValid;
    if (pendValid && tDone[T_CMD]) begin
      if (!rowOpen)
        strb.doAct = tDone[T_RP];
      else if (rowHit)
        strb.doRead = tDone[T_RCD] && tDone[T_GAP];
      else
        strb.doPre = tDone[T_RAS] && tDone[T_GAP];
    end
  end

  assign anyCmd = strb.doAct || strb.doRead || strb.doPre;
  assign reqReady = !pendValid;

  assign tLoad[T_CMD] = anyCmd;
  assign tLoad[T_RCD] = strb.doAct;
  assign tLoad[T_RAS] = strb.doAct;
  assign tLoad[T_RP]  = strb.doPre;
  assign tLoad[T_GAP] = strb.doRead;
  assign tVal[T_CMD]  = cfgRate2 ? TW'(1) : '0;
  assign tVal[T_RCD]  = lessOne(cfgTrcd);
  assign tVal[T_RAS]  = lessOne(cfgTras);
  assign tVal[T_RP]   = lessOne(cfgTrp);
  assign tVal[T_GAP]  = TW'(burstLen - 4'd1);

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    seq_timer #(.W(TW)) u_tmr (
      .clk(clk), .rstN(rstN), .load(tLoad[i]), .loadVal(tVal[i]), .done(tDone[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      rowOpen   <= 1'b0;
    end else begin
      if (strb.capture)     pendValid <= 1'b1;
      else if (strb.doRead) pendValid <= 1'b0;
      if (strb.doAct)       rowOpen <= 1'b1;
      else if (strb.doPre)  rowOpen <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int TW     = 4,
  parameter int VW     = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [1:0]        reqBurst,
  input  logic [TW-1:0]     cfgCl,
  output logic              rowHit,
  output logic [3:0]        burstLen,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              rdValid
);
  logic [ROW_W-1:0]  pendRow, openRow;
  logic [COL_W-1:0]  pendCol;
  logic [1:0]        pendBurst;
  cmd_e              cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic [VW-1:0]     rdVec, burstMask;
  logic [TW-1:0]     clEff;

  assign rowHit   = (pendRow == openRow);
  assign burstLen = burstWords(pendBurst);
  assign clEff    = (cfgCl == '0) ? TW'(1) : cfgCl;

  for (genvar i = 0; i < VW; i++) begin : g_mask
    assign burstMask[i] = (i < 8) && (4'(i) < burstLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendRow   <= '0;
      pendCol   <= '0;
      pendBurst <= '0;
      openRow   <= '0;
    end else begin
      if (strb.capture) begin
        pendRow   <= reqRow;
        pendCol   <= reqCol;
        pendBurst <= reqBurst;
      end
      if (strb.doAct) openRow <= pendRow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
    end else if (strb.doAct) begin
      cmdQ  <= CMD_ACT;
      addrQ <= ADDR_W'(pendRow);
    end else if (strb.doRead) begin
      cmdQ  <= CMD_READ;
      addrQ <= ADDR_W'(pendCol);
    end else if (strb.doPre) begin
      cmdQ  <= CMD_PRE;
      addrQ <= '0;
    end else begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
    end
  end

  // bit 0 is the valid flag of the current cycle; a READ decision inserts
  // its burst mask CL positions up so it lands CL cycles after the command
  always_ff @(posedge clk) begin
    if (!rstN)            rdVec <= '0;
    else if (strb.doRead) rdVec <= (rdVec >> 1) | (burstMask << clEff);
    else                  rdVec <= rdVec >> 1;
  end

  assign {sdRasN, sdCasN, sdWeN} = cmdQ;
  assign sdAddr  = addrQ;
  assign rdValid = rdVec[0];
endmodule

// File: rtl/sdram_bank_seq.sv
module sdram_bank_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int TW    = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [1:0]        reqBurst,
  input  logic [TW-1:0]     cfgCl,
  input  logic [TW-1:0]     cfgTrcd,
  input  logic [TW-1:0]     cfgTrp,
  input  logic [TW-1:0]     cfgTras,
  input  logic              cfgRate2,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              rdValid
);
  localparam int VW = (1 << TW) + 8;

  strobe_t    strb;
  logic       rowHit;
  logic [3:0] burstLen;

  seq_ctrl #(.TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .burstLen(burstLen), .cfgTrcd(cfgTrcd), .cfgTrp(cfgTrp), .cfgTras(cfgTras),
    .cfgRate2(cfgRate2), .reqReady(reqReady), .strb(strb)
  );

  seq_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .TW(TW), .VW(VW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqRow(reqRow), .reqCol(reqCol),
    .reqBurst(reqBurst), .cfgCl(cfgCl), .rowHit(rowHit), .burstLen(burstLen),
    .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN), .sdAddr(sdAddr), .rdValid(rdValid)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic [1:0]    reqBurst,
  input logic [TW-1:0] cfgTrcd,
  input logic [TW-1:0] cfgTrp,
  input logic [TW-1:0] cfgTras,
  input logic          cfgRate2,
  input logic          sdRasN,
  input logic          sdCasN,
  input logic          sdWeN
);
  logic [2:0] bus;
  logic isNop, isAct, isRead, isPre;
  logic [7:0] sinceAct, sinceRead, sincePre, sinceCmd;
  logic [3:0] pendBl, readBl;
  logic openM;

  assign bus    = {sdRasN, sdCasN, sdWeN};
  assign isNop  = (bus == 3'b111);
  assign isAct  = (bus == 3'b011);
  assign isRead = (bus == 3'b101);
  assign isPre  = (bus == 3'b010);

  function automatic logic [7:0] atLeast1(input logic [TW-1:0] v);
    atLeast1 = (v == '0) ? 8'd1 : 8'(v);
  endfunction

  function automatic logic [7:0] bump(input logic [7:0] v);
    bump = (v == 8'hff) ? v : v + 8'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAct <= 8'hff; sinceRead <= 8'hff; sincePre <= 8'hff; sinceCmd <= 8'hff;
      pendBl <= '0; readBl <= '0; openM <= 1'b0;
    end else begin
      sinceAct  <= isAct  ? 8'd1 : bump(sinceAct);
      sinceRead <= isRead ? 8'd1 : bump(sinceRead);
      sincePre  <= isPre  ? 8'd1 : bump(sincePre);
      sinceCmd  <= !isNop ? 8'd1 : bump(sinceCmd);
      if (reqValid && reqReady) pendBl <= burstWords(reqBurst);
      if (isRead) readBl <= pendBl;
      if (isAct) openM <= 1'b1;
      else if (isPre) openM <= 1'b0;
    end
  end

  p_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    isNop || isAct || isRead || isPre);
  p_rcd_r3: assert property (@(posedge clk) disable iff (!rstN)
    isRead |-> openM && (sinceAct >= atLeast1(cfgTrcd)));
  p_rdgap_r5: assert property (@(posedge clk) disable iff (!rstN)
    isRead |-> sinceRead >= {4'd0, readBl});
  p_tras_r6: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> openM && (sinceAct >= atLeast1(cfgTras)) && (sinceRead >= {4'd0, readBl}));
  p_trp_r7: assert property (@(posedge clk) disable iff (!rstN)
    isAct |-> !openM && (sincePre >= atLeast1(cfgTrp)));
  p_rate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !isNop |-> sinceCmd >= (cfgRate2 ? 8'd2 : 8'd1));
  p_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

bind sdram_bank_seq seq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqBurst(reqBurst), .cfgTrcd(cfgTrcd), .cfgTrp(cfgTrp), .cfgTras(cfgTras),
  .cfgRate2(cfgRate2), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN)
);

// File: tb/sim_sdram_bank_seq.sv
`timescale 1ns/1ps
module sim_sdram_bank_seq;
  localparam int ROW_W = 13, COL_W = 10, TW = 4, ADDR_W = 13;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic [1:0] reqBurst = '0;
  logic [TW-1:0] cfgCl = 4'd2, cfgTrcd = 4'd2, cfgTrp = 4'd2, cfgTras = 4'd8;
  logic cfgRate2 = 1'b0;
  logic sdRasN, sdCasN, sdWeN, rdValid;
  logic [ADDR_W-1:0] sdAddr;

  sdram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u0 (.*);

  always #2.5 clk = ~clk;

  int cycle = 0, nChk = 0, nFail = 0;
  bit finished = 0;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  function automatic int mx1(input int v); return (v < 1) ? 1 : v; endfunction
  function automatic int maxi(input int a, input int b); return (a > b) ? a : b; endfunction
  function automatic int words(input int code); return (code == 0) ? 2 : (code == 1) ? 4 : 8; endfunction

  // ---------------- bus monitor ----------------
  int lastAct = -1000, lastRead = -1000, prevRead = -1000, lastPre = -1000, lastCmd = -1000;
  int nReads = 0, preFromAct = 0, actAddr = 0, readAddr = 0;
  int acceptedBl = 2, readBl = 0;
  bit expV [256];

  always @(negedge clk) begin
    if (rstN) begin
      automatic logic [2:0] b = {sdRasN, sdCasN, sdWeN};
      automatic int idx = cycle % 256;
      if (rdValid || expV[idx]) chk(rdValid == expV[idx], "R4 rdValid", rdValid, expV[idx]);
      expV[idx] = 0;
      if (b != 3'b111) begin
        chk(cycle - lastCmd >= (cfgRate2 ? 2 : 1), "R8 command spacing", cycle - lastCmd, cfgRate2 ? 2 : 1);
        lastCmd = cycle;
      end
      if (b == 3'b011) begin
        chk(cycle - lastPre >= mx1(cfgTrp), "R7 PRE->ACT", cycle - lastPre, mx1(cfgTrp));
        lastAct = cycle; actAddr = sdAddr;
      end else if (b == 3'b101) begin
        chk(cycle - lastAct >= mx1(cfgTrcd), "R3 ACT->READ", cycle - lastAct, mx1(cfgTrcd));
        chk(cycle - lastRead >= readBl, "R5 READ->READ", cycle - lastRead, readBl);
        prevRead = lastRead; lastRead = cycle; readAddr = sdAddr;
        readBl = acceptedBl; nReads++;
        for (int k = 0; k < readBl; k++) expV[(cycle + mx1(cfgCl) + k) % 256] = 1;
      end else if (b == 3'b010) begin
        chk(cycle - lastAct >= mx1(cfgTras), "R6 ACT->PRE", cycle - lastAct, mx1(cfgTras));
        chk(cycle - lastRead >= readBl, "R6 READ->PRE", cycle - lastRead, readBl);
        preFromAct = cycle - lastAct; lastPre = cycle;
      end else if (b != 3'b111) begin
        chk(0, "R2 encoding", b, 7);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic sendReq(input int row, input int col, input int burst, output int acc);
    @(negedge clk);
    reqValid = 1'b1; reqRow = ROW_W'(row); reqCol = COL_W'(col); reqBurst = 2'(burst);
    while (!reqReady) @(negedge clk);
    acc = cycle;
    @(negedge clk);
    reqValid = 1'b0;
    acceptedBl = words(burst);
    chk(reqReady == 1'b0, "R9 ready low after accept", reqReady, 0);
  endtask

  task automatic waitReads(input int n);
    while (nReads < n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [12:0] row; logic [9:0] col; logic [1:0] burst;
    logic [3:0] cl, trcd, trp, tras; logic t2;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{13'd5,    10'd3,    2'd0, 4'd2,  4'd3,  4'd2,  4'd8,  1'b0},
    '{13'd5,    10'd9,    2'd1, 4'd3,  4'd3,  4'd2,  4'd8,  1'b0},
    '{13'd9,    10'd1,    2'd2, 4'd2,  4'd2,  4'd2,  4'd8,  1'b0},
    '{13'd9,    10'd20,   2'd3, 4'd4,  4'd2,  4'd2,  4'd8,  1'b1},
    '{13'd17,   10'd7,    2'd0, 4'd1,  4'd1,  4'd1,  4'd3,  1'b1},
    '{13'd17,   10'd0,    2'd1, 4'd5,  4'd4,  4'd3,  4'd10, 1'b0},
    '{13'd2,    10'd1023, 2'd2, 4'd2,  4'd5,  4'd4,  4'd12, 1'b0},
    '{13'd8191, 10'd0,    2'd0, 4'd15, 4'd15, 4'd15, 4'd15, 1'b0},
    '{13'd8191, 10'd5,    2'd1, 4'd3,  4'd3,  4'd3,  4'd8,  1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", cycle, 100000);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    automatic bit tbOpen = 0;
    automatic int tbRow = 0, acc = 0, actAt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({sdRasN, sdCasN, sdWeN} == 3'b111, "R1 NOP after reset", {sdRasN, sdCasN, sdWeN}, 7);
    chk(rdValid == 1'b0, "R1 rdValid after reset", rdValid, 0);
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);

    foreach (VEC[i]) begin
      automatic vec_t v = VEC[i];
      automatic int rate = v.t2 ? 2 : 1;
      automatic int n0 = nReads;
      automatic int expRead;
      cfgCl = v.cl; cfgTrcd = v.trcd; cfgTrp = v.trp; cfgTras = v.tras; cfgRate2 = v.t2;
      repeat (2) @(negedge clk);
      sendReq(v.row, v.col, v.burst, acc);
      waitReads(n0 + 1);
      if (tbOpen && tbRow == v.row) begin
        expRead = acc + 2;                                    // R5 hit
        chk(lastAct < acc, "R5 hit has no ACT", lastAct, acc);
      end else if (!tbOpen) begin
        actAt = acc + 2;                                      // R3 closed
        chk(lastAct == actAt, "R3 ACT cycle", lastAct, actAt);
        expRead = actAt + maxi(v.trcd, rate);
      end else begin
        chk(lastPre == acc + 2, "R6 PRE cycle", lastPre, acc + 2);
        actAt = acc + 2 + maxi(v.trp, rate);                  // R7
        chk(lastAct == actAt, "R7 ACT after PRE", lastAct, actAt);
        expRead = actAt + maxi(v.trcd, rate);
      end
      chk(lastRead == expRead, "R3/R5 READ cycle", lastRead, expRead);
      chk(readAddr == v.col, "R2 column on bus", readAddr, v.col);
      chk(actAddr == v.row, "R2 row on bus", actAddr, v.row);
      tbOpen = 1; tbRow = v.row;
      repeat (40) @(negedge clk);
    end

    // back-to-back 8-word hits: reads 8 apart, data continuous (R5, R4)
    cfgCl = 4'd2; cfgTrcd = 4'd2; cfgTrp = 4'd2; cfgTras = 4'd8; cfgRate2 = 1'b0;
    repeat (2) @(negedge clk);
    sendReq(40, 0, 2, acc);
    waitReads(nReads + 1);
    repeat (20) @(negedge clk);
    begin
      automatic int n0 = nReads;
      sendReq(40, 8, 2, acc);
      sendReq(40, 16, 2, acc);
      waitReads(n0 + 2);
      chk(lastRead - prevRead == 8, "R5 back-to-back spacing", lastRead - prevRead, 8);
    end
    repeat (30) @(negedge clk);

    // tRAS limits precharge after a short burst (R6)
    begin
      automatic int n0 = nReads;
      sendReq(41, 1, 0, acc);
      sendReq(42, 2, 0, acc);
      waitReads(n0 + 2);
      chk(preFromAct == 8, "R6 PRE waits for tRAS", preFromAct, 8);
    end
    repeat (30) @(negedge clk);
    chk(rdValid == 1'b0, "R4 rdValid idle", rdValid, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule